// File: doc/BRIEF.md
# Wide Virtual Address Segment Decoder

This block decides how a 64-bit virtual address is handled before any page-table lookup. The address falls in one of four regions: user mapped, supervisor mapped, the kernel's direct physical window, or kernel mapped. The decoder gives one of three outcomes for it: the address must go through translation, it maps straight to a physical address with read and write permission, or it is illegal. Addresses at the very top of the space belong to the 32-bit compatibility segments. The decoder only flags them and does not classify them further.

The upper legal bound of every mapped region comes from a mask built from the `SEG_BITS` parameter, which is the number of implemented virtual address bits inside a segment. The mask sets the two region-select bits and the low `SEG_BITS` bits. The same decoder therefore serves cores that implement 40, 42 or other segment widths.

Requests and responses are streams with valid/ready handshakes. The decode is purely combinational and holds no storage, so a response exists in the same cycle as its request.

Back-pressure rules:
- `req_ready` equals `rsp_ready`, so a stalled consumer stalls the producer.
- `rsp_valid` equals `req_valid`.
- A transfer happens in a cycle where both valid and ready are high.
- The producer must hold the request fields stable while it waits.

Top module: `xseg_decoder`

## Requirements
- R1: `seg_mask` has bits 63 and 62 set and bits `SEG_BITS-1` down to 0 set; every other bit is zero.
- R2: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in the same cycle; with `req_valid` low, `rsp_valid` is low.
- R3: `rsp_region` is set by the address as follows:
  - 2'b00 (user) below 0x3FFF_FFFF_FFFF_FFFF.
  - 2'b01 (supervisor) from that value up to, but not including, 0x7FFF_FFFF_FFFF_FFFF.
  - 2'b10 (kernel physical window) from that value up to, but not including, 0xBFFF_FFFF_FFFF_FFFF.
  - 2'b11 (kernel mapped) from that value up to, but not including, 0xFFFF_FFFF_7FFF_FFFF.
- R4: In the user region the result is mapped only when `req_ux` is 1 and the address is below (0x3FFF_FFFF_FFFF_FFFF AND `seg_mask`); otherwise it is bad.
- R5: In the supervisor region the result is mapped only when `req_sx` is 1 and the address is below (0x7FFF_FFFF_FFFF_FFFF AND `seg_mask`); otherwise it is bad.
- R6: In the kernel physical window the result is unmapped physical only when `req_kx` is 1 and (address AND 0x07FF_FFFF_FFFF_FFFF) is below 2^36-1. `rsp_paddr` then carries address bits 35:0. Otherwise the result is bad.
- R7: In the kernel mapped region the result is mapped only when `req_kx` is 1 and the address is below (0xFFFF_FFFF_7FFF_FFFF AND `seg_mask`); otherwise it is bad.
- R8: An address at or above 0xFFFF_FFFF_7FFF_FFFF drives `rsp_compat` to 1, `rsp_result` to bad, `rsp_region` to 2'b00 and `rsp_paddr` to zero. Below that bound `rsp_compat` is 0.
- R9: `rsp_result` encodes 2'b00 as bad, 2'b01 as mapped and 2'b10 as unmapped physical. `rsp_paddr` is zero unless the result is unmapped physical. An enable bit that does not belong to the address's region has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Request carries an address |
| req_ready | output | 1 | Decoder accepts the request (follows rsp_ready) |
| req_vaddr | input | 64 | Virtual address to decode |
| req_ux | input | 1 | User 64-bit addressing enable |
| req_sx | input | 1 | Supervisor 64-bit addressing enable |
| req_kx | input | 1 | Kernel 64-bit addressing enable |
| rsp_valid | output | 1 | Response is present (follows req_valid) |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_result | output | 2 | 00 bad, 01 mapped, 10 unmapped physical |
| rsp_region | output | 2 | 00 user, 01 supervisor, 10 kernel window, 11 kernel mapped |
| rsp_compat | output | 1 | Address lies in the compatibility segments |
| rsp_paddr | output | 36 | Physical address for the kernel window, else zero |
| seg_mask | output | 64 | Derived implemented-segment mask |

## Verification
The assertions are immediate checks on the settled combinational outputs. They assume the request fields are driven to known values and hold still for the whole cycle once applied. The bench changes inputs only just after a rising edge and samples at the falling edge, so every check sees a settled decode.

The stimulus sits on each region bound, one below it and at it. It also covers the kernel-window corners where bits 59 and 60 are dropped by the window mask, and it flips the enable bits of the other regions. The consumer's ready signal is toggled in a fixed pattern so that held requests are exercised.

// File: rtl/xseg_pkg.sv
`timescale 1ns/1ps
package xseg_pkg;

  localparam int VA_W = 64;

  typedef enum logic [1:0] {
    RES_BAD    = 2'b00,
    RES_MAPPED = 2'b01,
    RES_PHYS   = 2'b10
  } xseg_result_e;

  typedef enum logic [1:0] {
    REG_USER  = 2'b00,
    REG_SUPER = 2'b01,
    REG_KWIN  = 2'b10,
    REG_KMAP  = 2'b11
  } xseg_region_e;

  // exclusive upper bounds of each region, checked in ascending order
  localparam logic [VA_W-1:0] USER_TOP  = 64'h3FFF_FFFF_FFFF_FFFF;
  localparam logic [VA_W-1:0] SUPER_TOP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [VA_W-1:0] KWIN_TOP  = 64'hBFFF_FFFF_FFFF_FFFF;
  localparam logic [VA_W-1:0] KMAP_TOP  = 64'hFFFF_FFFF_7FFF_FFFF;

  // the window ignores the top five address bits before its bound check
  localparam logic [VA_W-1:0] KWIN_KEEP = 64'h07FF_FFFF_FFFF_FFFF;

  localparam int N_MAPPED = 3;

  // index 0 user, 1 supervisor, 2 kernel mapped
  function automatic logic [VA_W-1:0] mapped_top(input int idx);
    case (idx)
      0:       mapped_top = USER_TOP;
      1:       mapped_top = SUPER_TOP;
      default: mapped_top = KMAP_TOP;
    endcase
  endfunction

endpackage

// File: rtl/xseg_mask_gen.sv
`timescale 1ns/1ps
module xseg_mask_gen #(
  parameter int SEG_BITS = 40,
  parameter int VA_W     = 64
) (
  output logic [VA_W-1:0] mask
);
  localparam int SEL_LO = VA_W - 2;

  for (genvar b = 0; b < VA_W; b++) begin : g_bit
    if (b >= SEL_LO || b < SEG_BITS) begin : g_one
      assign mask[b] = 1'b1;
    end else begin : g_zero
      assign mask[b] = 1'b0;
    end
  end
endmodule

// File: rtl/xseg_region_sel.sv
`timescale 1ns/1ps
module xseg_region_sel
  import xseg_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  output xseg_region_e    region,
  output logic            compat
);
  always_comb begin
    compat = 1'b0;
    region = REG_USER;
    if (vaddr < USER_TOP) begin
      region = REG_USER;
    end else if (vaddr < SUPER_TOP) begin
      region = REG_SUPER;
    end else if (vaddr < KWIN_TOP) begin
      region = REG_KWIN;
    end else if (vaddr < KMAP_TOP) begin
      region = REG_KMAP;
    end else begin
      compat = 1'b1;
    end
  end
endmodule

// File: rtl/xseg_limit_chk.sv
`timescale 1ns/1ps
module xseg_limit_chk
  import xseg_pkg::*;
#(
  parameter int SEG_BITS = 40,
  parameter int PA_W     = 36
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [VA_W-1:0] mask,
  input  logic            ux,
  input  logic            sx,
  input  logic            kx,
  input  xseg_region_e    region,
  input  logic            compat,
  output xseg_result_e    result,
  output logic [PA_W-1:0] paddr
);
  localparam logic [VA_W-1:0] KWIN_LIM = (64'd1 << PA_W) - 64'd1;

  logic [N_MAPPED-1:0] below;
  logic [N_MAPPED-1:0] enable;
  logic                kwin_ok;

  assign enable = {kx, sx, ux};

  for (genvar g = 0; g < N_MAPPED; g++) begin : g_lim
    localparam logic [VA_W-1:0] TOP = mapped_top(g);
    assign below[g] = vaddr < (TOP & mask);
  end

  assign kwin_ok = kx && ((vaddr & KWIN_KEEP) < KWIN_LIM);

  always_comb begin
    result = RES_BAD;
    paddr  = '0;
    if (!compat) begin
      unique case (region)
        REG_USER:  if (enable[0] && below[0]) result = RES_MAPPED;
        REG_SUPER: if (enable[1] && below[1]) result = RES_MAPPED;
        REG_KMAP:  if (enable[2] && below[2]) result = RES_MAPPED;
        REG_KWIN: begin
          if (kwin_ok) begin
            result = RES_PHYS;
            paddr  = vaddr[PA_W-1:0];
          end
        end
        default: result = RES_BAD;
      endcase
    end
  end

  // a mapped user address never reaches past the implemented segment bits
  always_comb begin
    p_user_in_seg_r4: assert (!(result == RES_MAPPED && region == REG_USER && !compat)
                              || (vaddr >> SEG_BITS) == '0);
  end
endmodule

// File: rtl/xseg_decoder.sv
`timescale 1ns/1ps
module xseg_decoder
  import xseg_pkg::*;
#(
  parameter int SEG_BITS = 40,
  parameter int PA_W     = 36
) (
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic            req_ux,
  input  logic            req_sx,
  input  logic            req_kx,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_result,
  output logic [1:0]      rsp_region,
  output logic            rsp_compat,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [63:0]     seg_mask
);
  xseg_region_e region_w;
  xseg_result_e result_w;
  logic         compat_w;

  assign req_ready = rsp_ready;
  assign rsp_valid = req_valid;

  xseg_mask_gen #(.SEG_BITS(SEG_BITS), .VA_W(VA_W)) mask_i (
    .mask (seg_mask)
  );

  xseg_region_sel sel_i (
    .vaddr  (req_vaddr),
    .region (region_w),
    .compat (compat_w)
  );

  xseg_limit_chk #(.SEG_BITS(SEG_BITS), .PA_W(PA_W)) chk_i (
    .vaddr  (req_vaddr),
    .mask   (seg_mask),
    .ux     (req_ux),
    .sx     (req_sx),
    .kx     (req_kx),
    .region (region_w),
    .compat (compat_w),
    .result (result_w),
    .paddr  (rsp_paddr)
  );

  assign rsp_result = result_w;
  assign rsp_compat = compat_w;
  assign rsp_region = compat_w ? REG_USER : region_w;

  always_comb begin
    p_phys_in_window_r6: assert (rsp_result != RES_PHYS
                                 || (rsp_region == REG_KWIN && !rsp_compat));
    p_paddr_idle_r9:     assert (rsp_result == RES_PHYS || rsp_paddr == '0);
    p_compat_bad_r8:     assert (!rsp_compat || rsp_result == RES_BAD);
    p_result_legal_r9:   assert (rsp_result != 2'b11);
    p_mask_cover_r1:     assert (rsp_result != RES_MAPPED || rsp_compat
                                 || ((req_vaddr & ~seg_mask) == '0)
                                 || rsp_region == REG_SUPER
                                 || rsp_region == REG_KMAP);
  end
endmodule

// File: tb/xseg_decoder_tb_top.sv
`timescale 1ns/1ps
module xseg_decoder_tb_top;
  localparam int SEG   = 40;
  localparam int PA    = 36;
  localparam int MAXCY = 20000;

  typedef struct {
    logic [1:0]    res;
    logic [1:0]    reg_c;
    logic          cmp;
    logic [PA-1:0] pa;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_vaddr = '0;
  logic req_ux = 1'b0, req_sx = 1'b0, req_kx = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [1:0] rsp_result, rsp_region;
  logic rsp_compat;
  logic [PA-1:0] rsp_paddr;
  logic [63:0] seg_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  xseg_decoder #(.SEG_BITS(SEG), .PA_W(PA)) dut_i (
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_ux(req_ux), .req_sx(req_sx), .req_kx(req_kx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_result(rsp_result),
    .rsp_region(rsp_region), .rsp_compat(rsp_compat), .rsp_paddr(rsp_paddr),
    .seg_mask(seg_mask)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outcome written from the requirement text
  function automatic exp_t model(input logic [63:0] a, input logic ux, sx, kx,
                                 input string tag);
    exp_t e;
    logic [63:0] m;
    m = (64'h3 << 62) | ((64'h1 << SEG) - 64'h1);
    e.res = 2'b00; e.reg_c = 2'b00; e.cmp = 1'b0; e.pa = '0; e.tag = tag;
    if (a < 64'h3FFF_FFFF_FFFF_FFFF) begin
      e.reg_c = 2'b00;
      if (ux && a < (64'h3FFF_FFFF_FFFF_FFFF & m)) e.res = 2'b01;
    end else if (a < 64'h7FFF_FFFF_FFFF_FFFF) begin
      e.reg_c = 2'b01;
      if (sx && a < (64'h7FFF_FFFF_FFFF_FFFF & m)) e.res = 2'b01;
    end else if (a < 64'hBFFF_FFFF_FFFF_FFFF) begin
      e.reg_c = 2'b10;
      if (kx && (a & 64'h07FF_FFFF_FFFF_FFFF) < 64'h0000_000F_FFFF_FFFF) begin
        e.res = 2'b10;
        e.pa  = a[PA-1:0];
      end
    end else if (a < 64'hFFFF_FFFF_7FFF_FFFF) begin
      e.reg_c = 2'b11;
      if (kx && a < (64'hFFFF_FFFF_7FFF_FFFF & m)) e.res = 2'b01;
    end else begin
      e.cmp = 1'b1;
    end
    return e;
  endfunction

  task automatic send(input logic [63:0] a, input logic ux, sx, kx, input string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = a; req_ux = ux; req_sx = sx; req_kx = kx;
    q.push_back(model(a, ux, sx, kx, tag));
    forever begin
      @(negedge clk); #1;
      if (req_ready) break;
    end
  endtask

  // monitor: pops one expected item per completed transfer
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      check("R2 rsp_valid follows req_valid", {63'd0, rsp_valid}, 64'd1);
      check("R2 req_ready follows rsp_ready", {63'd0, req_ready}, {63'd0, rsp_ready});
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          check("R2 unexpected transfer", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " result"}, {62'd0, rsp_result}, {62'd0, e.res});
          check({"R3 ", e.tag, " region"}, {62'd0, rsp_region}, {62'd0, e.reg_c});
          check({"R8 ", e.tag, " compat"}, {63'd0, rsp_compat}, {63'd0, e.cmp});
          check({"R9 ", e.tag, " paddr"}, {28'd0, rsp_paddr}, {28'd0, e.pa});
        end
      end
    end
  end

  // consumer back-pressure pattern
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #2;
      k++;
      rsp_ready = rst ? 1'b0 : ((k % 5) != 2);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(MAXCY * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] em;
    repeat (3) @(negedge clk);
    check("R2 reset rsp_valid low", {63'd0, rsp_valid}, 64'd0);
    em = (64'h3 << 62) | ((64'h1 << SEG) - 64'h1);
    check("R1 seg_mask", seg_mask, em);
    check("R1 seg_mask value", seg_mask, 64'hC000_00FF_FFFF_FFFF);
    @(posedge clk); #1 rst = 1'b0;

    // user region, R4
    send(64'h0000_0000_0000_1000, 1, 0, 0, "R4 user low");
    send(64'h0000_00FF_FFFF_FFFE, 1, 0, 0, "R4 user last");
    send(64'h0000_00FF_FFFF_FFFF, 1, 0, 0, "R4 user at bound");
    send(64'h0000_0100_0000_0000, 1, 1, 1, "R4 user beyond");
    send(64'h0000_0000_0000_1000, 0, 1, 1, "R9 user other enables");
    send(64'h3FFF_FFFF_FFFF_FFFE, 1, 1, 1, "R3 user top");
    // supervisor region, R5
    send(64'h3FFF_FFFF_FFFF_FFFF, 0, 1, 0, "R5 super first");
    send(64'h4000_00FF_FFFF_FFFE, 0, 1, 0, "R5 super last");
    send(64'h4000_00FF_FFFF_FFFF, 0, 1, 0, "R5 super at bound");
    send(64'h4000_0000_0000_2000, 1, 0, 1, "R9 super other enables");
    send(64'h7FFF_FFFF_FFFF_FFFE, 1, 1, 1, "R5 super top");
    // kernel window, R6
    send(64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 1, "R6 window first");
    send(64'h8000_0000_1234_5678, 0, 0, 1, "R6 window low");
    send(64'h8000_000F_FFFF_FFFE, 0, 0, 1, "R6 window last");
    send(64'h8000_000F_FFFF_FFFF, 0, 0, 1, "R6 window at bound");
    send(64'h9000_0000_0000_1000, 0, 0, 1, "R6 window bit60 dropped");
    send(64'h8800_0000_0000_4000, 0, 0, 1, "R6 window bit59 dropped");
    send(64'h8400_0000_0000_0000, 0, 0, 1, "R6 window bit58 kept");
    send(64'h8000_0000_1234_5678, 1, 1, 0, "R9 window other enables");
    // kernel mapped, R7
    send(64'hBFFF_FFFF_FFFF_FFFF, 0, 0, 1, "R7 kmap first");
    send(64'hC000_00FF_7FFF_FFFE, 0, 0, 1, "R7 kmap last");
    send(64'hC000_00FF_7FFF_FFFF, 0, 0, 1, "R7 kmap at bound");
    send(64'hC000_0100_0000_0000, 0, 0, 1, "R7 kmap beyond");
    send(64'hC000_0000_0000_0000, 1, 1, 0, "R9 kmap other enables");
    // compatibility, R8
    send(64'hFFFF_FFFF_7FFF_FFFE, 1, 1, 1, "R8 below compat");
    send(64'hFFFF_FFFF_7FFF_FFFF, 1, 1, 1, "R8 compat first");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, "R8 compat top");

    @(posedge clk); #1 req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 queue drained", {32'd0, q.size()}, 64'd0);
    check("R2 idle rsp_valid low", {63'd0, rsp_valid}, 64'd0);
    finish_run();
  end
endmodule